// File: doc/BRIEF.md
# I2C Transfer Byte Buffer with Threshold Requests

This block sits between the register interface of an I2C controller and its bus engine. It keeps two byte queues: a transmit queue that software fills through the data port and the engine empties, and a receive queue that the engine fills and software empties. Each direction has its own threshold, set in a configuration word. When a threshold's worth of bytes can be moved, the block raises a ready request.

The block also takes the number of bytes the current transfer still has to move on the bus. Near the end of a transfer the remaining count can fall below the threshold. A full burst is then no longer possible, so the block raises a drain request in place of the ready request. Software reads a status word to learn how many bytes to move in that final burst. The status word also reports the queue depth, the receive level and the transmit bytes still owed.

Each direction's request comes from a small state machine with three states: `REQ_IDLE`, `REQ_READY` and `REQ_DRAIN`. On every clock the machine moves to `REQ_READY` when the ready condition holds. Otherwise it moves to `REQ_DRAIN` when the drain condition holds, and otherwise to `REQ_IDLE`. A flush of that direction overrides all of this and sends the machine to `REQ_IDLE`. The transitions are therefore: IDLE→READY, IDLE→DRAIN, READY→DRAIN, DRAIN→READY, any→IDLE on no condition, and any→IDLE on flush.

Top module: `i2c_xfer_fifo`

## Requirements
- R1: After reset both queues are empty, `cfg_rdata` is 0, all request and overflow outputs are low, and `stat_word` shows only the depth code in bits [15:14].
- R2: The configuration word is laid out as follows. Bits [13:8] hold the receive threshold minus one and bits [5:0] hold the transmit threshold minus one. Bit 15 enables receive DMA and bit 7 enables transmit DMA. A write stores these fields, and `cfg_rdata` returns them with bits 14 and 6 reading 0.
- R3: Writing bit 14 as 1 empties the receive queue, and writing bit 6 as 1 empties the transmit queue. Either flush takes effect at the edge that takes the write. A push into the same queue in that cycle is dropped, and the flush bit is never stored.
- R4: Each queue delivers bytes in the order they entered. The head byte is presented combinationally: `dat_rdata` for the receive queue and `eng_tx_byte` for the transmit queue.
- R5: The status word is built as follows. Bits [15:14] hold the depth code, and the depth is 8 shifted left by that code. Bits [13:8] hold the receive level. Bits [5:0] hold the transmit bytes still owed, which is max(`xfer_left` − transmit level, 0). Both fields saturate at 63, and bits [7:6] read 0.
- R6: Each request is registered, so it reflects the conditions of the previous cycle. Ready and drain for the same direction are never high together, and a flush forces both low at the next edge.
- R7: Receive ready is raised when the receive level is at least the receive threshold.
- R8: Receive drain is raised when `xfer_left` is 0 and the receive level is between 1 and the threshold minus one.
- R9: Transmit ready is raised when the bytes owed and the free space are both at least the transmit threshold.
- R10: Transmit drain is raised when the bytes owed are nonzero and below the threshold, and the free space covers them.
- R11: A write to a full transmit queue, or a push into a full receive queue, is dropped. The matching overflow output then pulses high for exactly the next cycle.
- R12: A pop from an empty queue leaves it unchanged. `eng_tx_avail` shows that the transmit queue is not empty, and `eng_rx_space` shows that the receive queue is not full.
- R13: `rx_dma_req` equals the receive DMA enable ANDed with (receive ready OR receive drain). `tx_dma_req` is formed the same way from the transmit DMA enable and the transmit requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Stored configuration |
| dat_wr | input | 1 | Software writes a transmit byte |
| dat_wdata | input | 8 | Transmit byte from software |
| dat_rd | input | 1 | Software pops a receive byte |
| dat_rdata | output | 8 | Receive queue head byte |
| eng_tx_pop | input | 1 | Engine takes a transmit byte |
| eng_tx_byte | output | 8 | Transmit queue head byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte from engine |
| eng_rx_space | output | 1 | Receive queue not full |
| xfer_left | input | 16 | Bytes the current transfer still has to move on the bus |
| stat_word | output | 16 | Depth code, receive level, transmit bytes owed |
| tx_ready | output | 1 | Transmit threshold burst request |
| tx_drain | output | 1 | Transmit final-burst request |
| rx_ready | output | 1 | Receive threshold burst request |
| rx_drain | output | 1 | Receive final-burst request |
| tx_dma_req | output | 1 | Transmit request routed to DMA |
| rx_dma_req | output | 1 | Receive request routed to DMA |
| tx_ovf | output | 1 | Transmit overflow pulse |
| rx_ovf | output | 1 | Receive overflow pulse |

## Verification
The assertions take the following for granted about the inputs:
- Strobes are sampled only at clock edges.
- Only one transfer direction is active at a time, since both directions read the same `xfer_left`.
- Thresholds do not exceed the queue depth.

The stimulus drives every input just after a rising edge and holds it for one full cycle. It runs the transmit and receive phases one after the other, and it keeps both thresholds at or below the default depth of 16. It also pushes each queue past full on purpose, so the overflow properties are exercised inside these limits.

// File: rtl/i2c_xf_pkg.sv
package i2c_xf_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READY = 2'd1,
        REQ_DRAIN = 2'd2
    } req_state_e;

    localparam int CFG_W        = 16;
    localparam int TH_W         = 6;
    localparam int RX_TH_LSB    = 8;
    localparam int TX_TH_LSB    = 0;
    localparam int RX_FLUSH_BIT = 14;
    localparam int TX_FLUSH_BIT = 6;
    localparam int RX_DMA_BIT   = 15;
    localparam int TX_DMA_BIT   = 7;
    localparam int FIELD_MAX    = (1 << TH_W) - 1;

endpackage

// File: rtl/xf_byte_fifo.sv
module xf_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [LW-1:0] level,
    output logic          overflow
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          is_full;
    logic          is_empty;
    logic          take_in;
    logic          take_out;

    assign is_full   = (level == LW'(DEPTH));
    assign is_empty  = (level == '0);
    assign take_in   = push && !is_full && !flush;
    assign take_out  = pop && !is_empty && !flush;
    assign head_data = store[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= push && is_full && !flush;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                level  <= '0;
            end else begin
                if (take_in)  wr_ptr <= wr_ptr + AW'(1);
                if (take_out) rd_ptr <= rd_ptr + AW'(1);
                unique case ({take_in, take_out})
                    2'b10:   level <= level + LW'(1);
                    2'b01:   level <= level - LW'(1);
                    default: level <= level;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take_in) store[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/xf_req_cond.sv
module xf_req_cond #(
    parameter bit IS_TX  = 1'b1,
    parameter int DEPTH  = 16,
    parameter int LW     = 5,
    parameter int XFER_W = 16
) (
    input  logic [LW-1:0]     level,
    input  logic [5:0]        thr_m1,
    input  logic [XFER_W-1:0] xfer_left,
    output logic              ready_c,
    output logic              drain_c,
    output logic [5:0]        status_field
);
    localparam int CW = XFER_W + 2;

    logic [CW-1:0] thr;
    logic [CW-1:0] lvl;
    logic [CW-1:0] left;
    logic [CW-1:0] free_sp;

    assign thr     = CW'(thr_m1) + CW'(1);
    assign lvl     = CW'(level);
    assign left    = CW'(xfer_left);
    assign free_sp = CW'(DEPTH) - lvl;

    generate
        if (IS_TX) begin : g_tx
            logic [CW-1:0] owed;
            assign owed         = (left > lvl) ? (left - lvl) : '0;
            assign ready_c      = (owed >= thr) && (free_sp >= thr);
            assign drain_c      = (owed != '0) && (owed < thr) && (free_sp >= owed);
            assign status_field = (owed > CW'(63)) ? 6'd63 : owed[5:0];
        end else begin : g_rx
            assign ready_c      = (lvl >= thr);
            assign drain_c      = (left == '0) && (lvl != '0) && (lvl < thr);
            assign status_field = (lvl > CW'(63)) ? 6'd63 : lvl[5:0];
        end
    endgenerate

endmodule

// File: rtl/xf_req_fsm.sv
module xf_req_fsm
    import i2c_xf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ready_c,
    input  logic drain_c,
    output logic ready_req,
    output logic drain_req
);
    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE, REQ_READY, REQ_DRAIN: begin
                if (clear)        state_d = REQ_IDLE;
                else if (ready_c) state_d = REQ_READY;
                else if (drain_c) state_d = REQ_DRAIN;
                else              state_d = REQ_IDLE;
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        ready_req = 1'b0;
        drain_req = 1'b0;
        unique case (state_q)
            REQ_READY: ready_req = 1'b1;
            REQ_DRAIN: drain_req = 1'b1;
            default: begin
                ready_req = 1'b0;
                drain_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2c_xfer_fifo.sv
module i2c_xfer_fifo
    import i2c_xf_pkg::*;
#(
    parameter int DEPTH_CODE = 1,
    parameter int XFER_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              dat_wr,
    input  logic [7:0]        dat_wdata,
    input  logic              dat_rd,
    output logic [7:0]        dat_rdata,
    input  logic              eng_tx_pop,
    output logic [7:0]        eng_tx_byte,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_byte,
    output logic              eng_rx_space,
    input  logic [XFER_W-1:0] xfer_left,
    output logic [15:0]       stat_word,
    output logic              tx_ready,
    output logic              tx_drain,
    output logic              rx_ready,
    output logic              rx_drain,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              tx_ovf,
    output logic              rx_ovf
);
    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int LW    = $clog2(DEPTH + 1);

    logic [TH_W-1:0] rx_thr_m1;
    logic [TH_W-1:0] tx_thr_m1;
    logic            rx_dma_en;
    logic            tx_dma_en;
    logic            rx_flush;
    logic            tx_flush;
    logic [LW-1:0]   rx_level;
    logic [LW-1:0]   tx_level;
    logic            rx_ready_c, rx_drain_c, tx_ready_c, tx_drain_c;
    logic [5:0]      rx_field, tx_field;

    assign rx_flush = cfg_wr && cfg_wdata[RX_FLUSH_BIT];
    assign tx_flush = cfg_wr && cfg_wdata[TX_FLUSH_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_thr_m1 <= '0;
            tx_thr_m1 <= '0;
            rx_dma_en <= 1'b0;
            tx_dma_en <= 1'b0;
        end else if (cfg_wr) begin
            rx_thr_m1 <= cfg_wdata[RX_TH_LSB +: TH_W];
            tx_thr_m1 <= cfg_wdata[TX_TH_LSB +: TH_W];
            rx_dma_en <= cfg_wdata[RX_DMA_BIT];
            tx_dma_en <= cfg_wdata[TX_DMA_BIT];
        end
    end

    assign cfg_rdata = {rx_dma_en, 1'b0, rx_thr_m1, tx_dma_en, 1'b0, tx_thr_m1};

    xf_byte_fifo #(.DW(8), .DEPTH(DEPTH), .LW(LW)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (dat_wr),
        .push_data (dat_wdata),
        .pop       (eng_tx_pop),
        .head_data (eng_tx_byte),
        .level     (tx_level),
        .overflow  (tx_ovf)
    );

    xf_byte_fifo #(.DW(8), .DEPTH(DEPTH), .LW(LW)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_byte),
        .pop       (dat_rd),
        .head_data (dat_rdata),
        .level     (rx_level),
        .overflow  (rx_ovf)
    );

    xf_req_cond #(.IS_TX(1'b1), .DEPTH(DEPTH), .LW(LW), .XFER_W(XFER_W)) u_tx_cond (
        .level        (tx_level),
        .thr_m1       (tx_thr_m1),
        .xfer_left    (xfer_left),
        .ready_c      (tx_ready_c),
        .drain_c      (tx_drain_c),
        .status_field (tx_field)
    );

    xf_req_cond #(.IS_TX(1'b0), .DEPTH(DEPTH), .LW(LW), .XFER_W(XFER_W)) u_rx_cond (
        .level        (rx_level),
        .thr_m1       (rx_thr_m1),
        .xfer_left    (xfer_left),
        .ready_c      (rx_ready_c),
        .drain_c      (rx_drain_c),
        .status_field (rx_field)
    );

    xf_req_fsm u_tx_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_flush),
        .ready_c   (tx_ready_c),
        .drain_c   (tx_drain_c),
        .ready_req (tx_ready),
        .drain_req (tx_drain)
    );

    xf_req_fsm u_rx_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_flush),
        .ready_c   (rx_ready_c),
        .drain_c   (rx_drain_c),
        .ready_req (rx_ready),
        .drain_req (rx_drain)
    );

    assign eng_tx_avail = (tx_level != '0);
    assign eng_rx_space = (rx_level != LW'(DEPTH));
    assign stat_word    = {2'(DEPTH_CODE), rx_field, 2'b00, tx_field};
    assign tx_dma_req   = tx_dma_en && (tx_ready || tx_drain);
    assign rx_dma_req   = rx_dma_en && (rx_ready || rx_drain);

endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [15:0]   cfg_wdata,
    input logic          dat_wr,
    input logic          eng_rx_push,
    input logic          eng_rx_space,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic [5:0]    rx_thr_m1,
    input logic          tx_ready,
    input logic          tx_drain,
    input logic          rx_ready,
    input logic          rx_drain,
    input logic          tx_ovf,
    input logic          rx_ovf
);
    a_r3_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[14]) |=> (rx_level == '0));

    a_r3_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[6]) |=> (tx_level == '0));

    a_r6_rx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && rx_drain));

    a_r6_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && tx_drain));

    a_r7_rx_ready_basis: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> (int'($past(rx_level)) > int'($past(rx_thr_m1))));

    a_r11_tx_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |-> ($past(dat_wr) && (int'($past(tx_level)) == DEPTH)));

    a_r11_rx_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> $past(eng_rx_push && !eng_rx_space));

    a_r12_rx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_level) <= DEPTH);

    a_r12_tx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_level) <= DEPTH);

endmodule

bind i2c_xfer_fifo xf_checker #(.DEPTH(DEPTH), .LW(LW)) u_xf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .dat_wr       (dat_wr),
    .eng_rx_push  (eng_rx_push),
    .eng_rx_space (eng_rx_space),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .rx_thr_m1    (rx_thr_m1),
    .tx_ready     (tx_ready),
    .tx_drain     (tx_drain),
    .rx_ready     (rx_ready),
    .rx_drain     (rx_drain),
    .tx_ovf       (tx_ovf),
    .rx_ovf       (rx_ovf)
);

// File: tb/test_i2c_xfer_fifo.sv
`timescale 1ns/1ps
module test_i2c_xfer_fifo;
    localparam int DCODE = 1;
    localparam int DEPTH = 8 << DCODE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        dat_wr = 1'b0;
    logic [7:0]  dat_wdata = '0;
    logic        dat_rd = 1'b0;
    logic [7:0]  dat_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_avail;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_space;
    logic [15:0] xfer_left = '0;
    logic [15:0] stat_word;
    logic        tx_ready, tx_drain, rx_ready, rx_drain;
    logic        tx_dma_req, rx_dma_req, tx_ovf, rx_ovf;

    i2c_xfer_fifo #(.DEPTH_CODE(DCODE)) i_i2c_xfer_fifo (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    // behavioural reference
    byte unsigned txq[$];
    byte unsigned rxq[$];
    int  m_rxth = 1, m_txth = 1;
    bit  m_rxdma = 0, m_txdma = 0;
    int  st_tx = 0, st_rx = 0;   // 0 idle, 1 ready, 2 drain
    bit  e_tx_ovf = 0, e_rx_ovf = 0;

    function automatic int owed(int left, int lvl);
        return (left > lvl) ? left - lvl : 0;
    endfunction

    function automatic int sat63(int v);
        return (v > 63) ? 63 : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_rxth = 1; m_txth = 1; m_rxdma = 0; m_txdma = 0;
            st_tx = 0; st_rx = 0; e_tx_ovf = 0; e_rx_ovf = 0;
            model_on = 1'b1;
        end else begin
            int tl, rl, lf, ow, fr, nst_tx, nst_rx;
            bit fl_rx, fl_tx;
            tl = txq.size(); rl = rxq.size(); lf = int'(xfer_left);
            fl_rx = cfg_wr && cfg_wdata[14];
            fl_tx = cfg_wr && cfg_wdata[6];
            ow = owed(lf, tl); fr = DEPTH - tl;
            if (fl_tx) nst_tx = 0;
            else if (ow >= m_txth && fr >= m_txth) nst_tx = 1;
            else if (ow != 0 && ow < m_txth && fr >= ow) nst_tx = 2;
            else nst_tx = 0;
            if (fl_rx) nst_rx = 0;
            else if (rl >= m_rxth) nst_rx = 1;
            else if (lf == 0 && rl != 0 && rl < m_rxth) nst_rx = 2;
            else nst_rx = 0;
            st_tx = nst_tx; st_rx = nst_rx;
            e_tx_ovf = dat_wr && tl == DEPTH && !fl_tx;
            e_rx_ovf = eng_rx_push && rl == DEPTH && !fl_rx;
            if (fl_tx) txq.delete();
            else begin
                if (eng_tx_pop && tl > 0) void'(txq.pop_front());
                if (dat_wr && tl < DEPTH) txq.push_back(dat_wdata);
            end
            if (fl_rx) rxq.delete();
            else begin
                if (dat_rd && rl > 0) void'(rxq.pop_front());
                if (eng_rx_push && rl < DEPTH) rxq.push_back(eng_rx_byte);
            end
            if (cfg_wr) begin
                m_rxth = int'(cfg_wdata[13:8]) + 1;
                m_txth = int'(cfg_wdata[5:0]) + 1;
                m_rxdma = cfg_wdata[15];
                m_txdma = cfg_wdata[7];
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            int exp_stat;
            exp_stat = (DCODE << 14) | (sat63(rxq.size()) << 8) |
                       sat63(owed(int'(xfer_left), txq.size()));
            chk("R2 cfg_rdata", int'(cfg_rdata),
                (int'(m_rxdma) << 15) | ((m_rxth - 1) << 8) | (int'(m_txdma) << 7) | (m_txth - 1));
            chk("R5 stat_word", int'(stat_word), exp_stat);
            chk("R7 rx_ready", int'(rx_ready), int'(st_rx == 1));
            chk("R8 rx_drain", int'(rx_drain), int'(st_rx == 2));
            chk("R9 tx_ready", int'(tx_ready), int'(st_tx == 1));
            chk("R10 tx_drain", int'(tx_drain), int'(st_tx == 2));
            chk("R6 exclusive", int'(rx_ready & rx_drain) + int'(tx_ready & tx_drain), 0);
            chk("R11 tx_ovf", int'(tx_ovf), int'(e_tx_ovf));
            chk("R11 rx_ovf", int'(rx_ovf), int'(e_rx_ovf));
            chk("R12 eng_tx_avail", int'(eng_tx_avail), int'(txq.size() != 0));
            chk("R12 eng_rx_space", int'(eng_rx_space), int'(rxq.size() != DEPTH));
            chk("R13 rx_dma_req", int'(rx_dma_req), int'(m_rxdma && st_rx != 0));
            chk("R13 tx_dma_req", int'(tx_dma_req), int'(m_txdma && st_tx != 0));
            if (txq.size() != 0) chk("R4 eng_tx_byte", int'(eng_tx_byte), int'(txq[0]));
            if (rxq.size() != 0) chk("R4 dat_rdata", int'(dat_rdata), int'(rxq[0]));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        cfg_wr = 0; dat_wr = 0; dat_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset stat_word", int'(stat_word), DCODE << 14);
        chk("R1 reset cfg_rdata", int'(cfg_rdata), 0);
        chk("R1 reset requests", int'({tx_ready, tx_drain, rx_ready, rx_drain, tx_ovf, rx_ovf}), 0);

        // thresholds 4/4 with both DMA enables
        cfg_wr = 1; cfg_wdata = 16'h8383; cyc();
        @(negedge clk);
        chk("R2 readback", int'(cfg_rdata), 16'h8383);

        // transmit: 6 bytes, ready burst then drain burst
        xfer_left = 16'd6; cyc(); cyc();
        @(negedge clk);
        chk("R9 tx_ready burst", int'(tx_ready), 1);
        for (int i = 0; i < 4; i++) begin dat_wr = 1; dat_wdata = 8'(8'h10 + i); cyc(); end
        cyc();
        @(negedge clk);
        chk("R10 tx_drain final burst", int'(tx_drain), 1);
        chk("R5 tx owed", int'(stat_word[5:0]), 2);
        for (int i = 0; i < 2; i++) begin dat_wr = 1; dat_wdata = 8'(8'h20 + i); cyc(); end
        cyc();
        for (int i = 0; i < 6; i++) begin
            eng_tx_pop = 1; xfer_left = xfer_left - 16'd1; cyc();
        end

        // transmit overflow, then flush with simultaneous write
        for (int i = 0; i < DEPTH + 1; i++) begin dat_wr = 1; dat_wdata = 8'(8'h40 + i); cyc(); end
        cfg_wr = 1; cfg_wdata = 16'h0343; dat_wr = 1; dat_wdata = 8'hEE; cyc();
        @(negedge clk);
        chk("R3 tx flush empties", int'(eng_tx_avail), 0);
        chk("R3 flush bit not stored", int'(cfg_rdata), 16'h0303);

        // pops from empty queues
        eng_tx_pop = 1; dat_rd = 1; cyc();
        @(negedge clk);
        chk("R12 empty pop", int'(stat_word[13:8]) + int'(eng_tx_avail), 0);

        // receive: 5 bytes, ready burst then drain
        xfer_left = 16'd5;
        for (int i = 0; i < 4; i++) begin
            eng_rx_push = 1; eng_rx_byte = 8'(8'h80 + i); xfer_left = xfer_left - 16'd1; cyc();
        end
        cyc();
        @(negedge clk);
        chk("R7 rx_ready burst", int'(rx_ready), 1);
        for (int i = 0; i < 4; i++) begin dat_rd = 1; cyc(); end
        eng_rx_push = 1; eng_rx_byte = 8'h99; xfer_left = 16'd0; cyc();
        cyc();
        @(negedge clk);
        chk("R8 rx_drain final", int'(rx_drain), 1);
        chk("R5 rx level", int'(stat_word[13:8]), 1);
        dat_rd = 1; cyc(); cyc();

        // receive overflow, then flush with simultaneous push
        xfer_left = 16'd40;
        for (int i = 0; i < DEPTH + 1; i++) begin
            eng_rx_push = 1; eng_rx_byte = 8'(8'hA0 + i); cyc();
        end
        cyc();
        cfg_wr = 1; cfg_wdata = 16'h4303; eng_rx_push = 1; eng_rx_byte = 8'h55; cyc();
        @(negedge clk);
        chk("R3 rx flush empties", int'(stat_word[13:8]), 0);
        chk("R6 flush clears request", int'(rx_ready), 0);

        // saturation of owed field
        xfer_left = 16'd100; cyc();
        @(negedge clk);
        chk("R5 owed saturates", int'(stat_word[5:0]), 63);

        // threshold one, no DMA
        cfg_wr = 1; cfg_wdata = 16'h0000; xfer_left = 16'd0; cyc();
        eng_rx_push = 1; eng_rx_byte = 8'h3C; cyc(); cyc();
        @(negedge clk);
        chk("R7 threshold one", int'(rx_ready), 1);
        chk("R13 dma disabled", int'(rx_dma_req), 0);
        dat_rd = 1; cyc(); cyc(); cyc();

        done = 1'b1;
        summary();
    end
endmodule